// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block sits between a set of interrupt request lines and a processor. It catches a rising edge on any line and holds it as pending. It then picks one pending line and offers it to the processor as a request with a line-index vector. The processor takes the offer with an acknowledge pulse. That pulse moves the line into an in-service set, which records every level whose handler is still running. When a handler finishes, the processor pulses end-of-interrupt. This pulse retires the most urgent level in the in-service set, and the controller falls back to whatever level was running underneath it.

A policy input selects one of two behaviours. When the policy is sequential, nothing is offered while any level is in service, and the waiting lines are handed out one at a time after each completion. When the policy is nested, a line that is strictly more urgent than every in-service level is offered at once, so its handler can preempt the running one. Lines of equal or lower urgency keep waiting.

The offer works as a valid/ready pair. `cpu_irq` is the valid signal and `cpu_ack` is the ready signal. A transfer happens on a clock edge where both are high. While no acknowledge arrives, the offer stays up and the controller holds it. The vector can change before the acknowledge only when a more urgent line becomes eligible or when the policy input changes. An acknowledge while `cpu_irq` is low does nothing.

Top module: `prio_irq_ctrl`

## Requirements
- R1: An asynchronous active-low reset clears the pending set, the in-service set and the stored previous line levels. While reset is held, `cpu_irq` is 0 and `cpu_vec` is 0.
- R2: A line becomes pending on the first clock edge where it is sampled high after being sampled low. After reset, a line that is already high counts as a new edge. A line that stays high after its acknowledge does not become pending again.
- R3: Line 0 is the most urgent and line N-1 the least. Among the eligible pending lines, the lowest-numbered one is offered, and `cpu_vec` carries its binary index. When nothing is offered, `cpu_vec` is 0.
- R4: An acknowledge while `cpu_irq` is high clears the offered line's pending bit and adds that line to the in-service set, in the same edge. An acknowledge while `cpu_irq` is low has no effect.
- R5: With `nest_en`=0 (sequential), `cpu_irq` stays low whenever the in-service set is non-empty. Edges that arrive during that time stay pending.
- R6: With `nest_en`=0, the waiting lines are offered after each end-of-interrupt empties the in-service set, one per service, in order of urgency.
- R7: With `nest_en`=1 (nested), a pending line whose index is below the lowest in-service index is offered in the cycle after its edge is caught.
- R8: With `nest_en`=1, a pending line whose index is equal to or above the lowest in-service index is not offered.
- R9: An end-of-interrupt removes the lowest-numbered line from the in-service set. Eligibility then returns to the level that the completed service had preempted.
- R10: An end-of-interrupt while the in-service set is empty has no effect.
- R11: When an acknowledge and an end-of-interrupt occur on the same edge, the end-of-interrupt acts on the in-service set as it was before that edge. The newly acknowledged line stays in service.
- R12: A rising edge that coincides with the acknowledge of the same line leaves the line pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lines | input | N_LINES | Request lines, sampled on each rising clock edge |
| nest_en | input | 1 | Policy: 0 sequential, 1 nested |
| cpu_irq | output | 1 | Offer valid toward the processor |
| cpu_vec | output | $clog2(N_LINES) | Index of the offered line |
| cpu_ack | input | 1 | Processor takes the current offer |
| cpu_eoi | input | 1 | Processor finished its most urgent active handler |

## Verification
Two functions can fall on the same edge: the acknowledge that pushes a level into the in-service set, and the end-of-interrupt that retires one. The bench provokes this collision with line 1 in service and line 0 being offered under the nested policy, and pulses both strobes on one edge. It judges the result indirectly. It lets line 0 fall and rise again: a correct design keeps line 0 in service, so the fresh request is blocked. A design that retired the wrong level would offer vector 0 at once. A second collision pairs an acknowledge with a new rising edge on the same line, and the check is that the line comes back as an offer after the end-of-interrupt.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic {
    POL_SEQ  = 1'b0,
    POL_NEST = 1'b1
  } policy_e;
endpackage

// File: rtl/irq_prio_pick.sv
// Fixed-priority picker: bit 0 wins. Gives a flag, a one-hot grant and a binary index.
module irq_prio_pick #(
  parameter  int W  = 8,
  localparam int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  req,
  output logic          any,
  output logic [W-1:0]  grant,
  output logic [IW-1:0] idx
);
  logic [W:0] seen;

  assign seen[0] = 1'b0;
  for (genvar g = 0; g < W; g++) begin : g_chain
    assign grant[g]  = req[g] & ~seen[g];
    assign seen[g+1] = seen[g] | req[g];
  end
  assign any = seen[W];

  always_comb begin
    idx = '0;
    for (int i = 0; i < W; i++) begin
      if (grant[i]) idx = idx | IW'(i);
    end
  end
endmodule

// File: rtl/irq_pend_latch.sv
// Edge catcher and pending store. A new edge wins over a clear on the same line.
module irq_pend_latch #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lines,
  input  logic         clr_en,
  input  logic [N-1:0] clr_sel,
  output logic [N-1:0] pend
);
  logic [N-1:0] prev_q;
  logic [N-1:0] rise;
  logic [N-1:0] clr_mask;

  assign rise     = lines & ~prev_q;
  assign clr_mask = clr_en ? clr_sel : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      pend   <= '0;
    end else begin
      prev_q <= lines;
      pend   <= (pend & ~clr_mask) | rise;
    end
  end
endmodule

// File: rtl/irq_svc_stack.sv
// In-service set. Retire removes the most urgent member as it stood before this edge.
module irq_svc_stack #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_en,
  input  logic [N-1:0] push_sel,
  input  logic         pop_en,
  output logic [N-1:0] active,
  output logic [N-1:0] top_sel,
  output logic         busy
);
  logic [N-1:0] add_mask;
  logic [N-1:0] drop_mask;

  assign top_sel   = active & (~active + N'(1));
  assign busy      = |active;
  assign add_mask  = push_en ? push_sel : '0;
  assign drop_mask = pop_en ? top_sel : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) active <= '0;
    else        active <= (active & ~drop_mask) | add_mask;
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import irq_pkg::*;
#(
  parameter  int N_LINES = 8,
  localparam int IDX_W   = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] irq_lines,
  input  logic               nest_en,
  output logic               cpu_irq,
  output logic [IDX_W-1:0]   cpu_vec,
  input  logic               cpu_ack,
  input  logic               cpu_eoi
);
  policy_e            pol;
  logic [N_LINES-1:0] pend_q;
  logic [N_LINES-1:0] isr_q;
  logic [N_LINES-1:0] isr_top;
  logic               isr_busy;
  logic [N_LINES-1:0] elig_mask;
  logic [N_LINES-1:0] grant;
  logic               offer;
  logic               take;

  assign pol = policy_e'(nest_en);

  // Lines more urgent than the top in-service level are the ones below its one-hot position.
  always_comb begin
    if (!isr_busy)            elig_mask = '1;
    else if (pol == POL_NEST) elig_mask = isr_top - N_LINES'(1);
    else                      elig_mask = '0;
  end

  irq_pend_latch #(.N(N_LINES)) u_pend (
    .clk     (clk),
    .rst_n   (rst_n),
    .lines   (irq_lines),
    .clr_en  (take),
    .clr_sel (grant),
    .pend    (pend_q)
  );

  irq_prio_pick #(.W(N_LINES)) u_pick (
    .req   (pend_q & elig_mask),
    .any   (offer),
    .grant (grant),
    .idx   (cpu_vec)
  );

  irq_svc_stack #(.N(N_LINES)) u_svc (
    .clk      (clk),
    .rst_n    (rst_n),
    .push_en  (take),
    .push_sel (grant),
    .pop_en   (cpu_eoi),
    .active   (isr_q),
    .top_sel  (isr_top),
    .busy     (isr_busy)
  );

  assign cpu_irq = offer;
  assign take    = cpu_ack & offer;
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk #(
  parameter  int N_LINES = 8,
  localparam int IW      = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               nest_en,
  input logic               cpu_irq,
  input logic [IW-1:0]      cpu_vec,
  input logic               cpu_ack,
  input logic               cpu_eoi,
  input logic [N_LINES-1:0] pend,
  input logic [N_LINES-1:0] isr
);
  function automatic logic [N_LINES-1:0] upto(input logic [IW-1:0] v, input bit incl);
    logic [N_LINES-1:0] r;
    for (int i = 0; i < N_LINES; i++) r[i] = incl ? (i <= int'(v)) : (i < int'(v));
    return r;
  endfunction

  // R5
  seq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!nest_en && (isr != '0)) |-> !cpu_irq);

  // R7
  nest_rank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq |-> ((isr & upto(cpu_vec, 1'b1)) == '0));

  // R3
  pick_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq |-> (pend[cpu_vec] && ((pend & upto(cpu_vec, 1'b0)) == '0)));

  // R4
  ack_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ack && cpu_irq) |=> isr[$past(cpu_vec)]);

  // R9
  eoi_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_eoi && !cpu_ack && (isr != '0)) |=> ($countones(isr) + 1 == $past($countones(isr))));

  // R10
  eoi_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_eoi && !(cpu_ack && cpu_irq) && (isr == '0)) |=> (isr == '0));
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(.N_LINES(N_LINES)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .nest_en (nest_en),
  .cpu_irq (cpu_irq),
  .cpu_vec (cpu_vec),
  .cpu_ack (cpu_ack),
  .cpu_eoi (cpu_eoi),
  .pend    (pend_q),
  .isr     (isr_q)
);

// File: tb/tb_prio_irq_ctrl.sv
module tb_prio_irq_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] irq_lines = '0;
  logic       nest_en = 1'b0;
  logic       cpu_ack = 1'b0;
  logic       cpu_eoi = 1'b0;
  logic       cpu_irq;
  logic [2:0] cpu_vec;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  prio_irq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .nest_en(nest_en),
    .cpu_irq(cpu_irq), .cpu_vec(cpu_vec), .cpu_ack(cpu_ack), .cpu_eoi(cpu_eoi)
  );

  // {req tag, lines, nest, ack, eoi, expected irq, expected vec}
  localparam int ROWS = 41;
  localparam logic [18:0] STIM [ROWS] = '{
    {4'd2,  8'h20, 1'b0, 1'b0, 1'b0, 1'b1, 3'd5},  // R2 edge on 5
    {4'd4,  8'h20, 1'b0, 1'b1, 1'b0, 1'b0, 3'd0},  // R4 take 5
    {4'd5,  8'h28, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0},  // R5 3 waits
    {4'd4,  8'h29, 1'b0, 1'b1, 1'b0, 1'b0, 3'd0},  // R4 stray ack, 0 waits
    {4'd6,  8'h29, 1'b0, 1'b0, 1'b1, 1'b1, 3'd0},  // R6 done, 0 first
    {4'd4,  8'h29, 1'b0, 1'b1, 1'b0, 1'b0, 3'd0},
    {4'd6,  8'h29, 1'b0, 1'b0, 1'b1, 1'b1, 3'd3},  // R6 then 3
    {4'd4,  8'h29, 1'b0, 1'b1, 1'b0, 1'b0, 3'd0},
    {4'd6,  8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 3'd0},
    {4'd3,  8'h20, 1'b1, 1'b0, 1'b0, 1'b1, 3'd5},  // R3
    {4'd4,  8'h20, 1'b1, 1'b1, 1'b0, 1'b0, 3'd0},
    {4'd7,  8'h24, 1'b1, 1'b0, 1'b0, 1'b1, 3'd2},  // R7 2 preempts 5
    {4'd4,  8'h24, 1'b1, 1'b1, 1'b0, 1'b0, 3'd0},
    {4'd8,  8'h2C, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0},  // R8 3 under 2
    {4'd8,  8'h6C, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0},
    {4'd9,  8'h6C, 1'b1, 1'b0, 1'b1, 1'b1, 3'd3},  // R9 back to 5, 3 eligible
    {4'd4,  8'h6C, 1'b1, 1'b1, 1'b0, 1'b0, 3'd0},
    {4'd8,  8'h6C, 1'b1, 1'b0, 1'b1, 1'b0, 3'd0},  // R8 6 under 5
    {4'd9,  8'h6C, 1'b1, 1'b0, 1'b1, 1'b1, 3'd6},
    {4'd4,  8'h6C, 1'b1, 1'b1, 1'b0, 1'b0, 3'd0},
    {4'd9,  8'h6C, 1'b1, 1'b0, 1'b1, 1'b0, 3'd0},
    {4'd10, 8'h6C, 1'b1, 1'b0, 1'b1, 1'b0, 3'd0},  // R10 idle eoi
    {4'd10, 8'h6E, 1'b1, 1'b0, 1'b0, 1'b1, 3'd1},
    {4'd4,  8'h6E, 1'b1, 1'b1, 1'b0, 1'b0, 3'd0},
    {4'd8,  8'h6C, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0},
    {4'd8,  8'h6E, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0},  // R8 equal level waits
    {4'd9,  8'h6E, 1'b1, 1'b0, 1'b1, 1'b1, 3'd1},
    {4'd4,  8'h6E, 1'b1, 1'b1, 1'b0, 1'b0, 3'd0},
    {4'd7,  8'h6F, 1'b1, 1'b0, 1'b0, 1'b1, 3'd0},
    {4'd11, 8'h6F, 1'b1, 1'b1, 1'b1, 1'b0, 3'd0},  // R11 ack and eoi together
    {4'd11, 8'h6E, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0},
    {4'd11, 8'h6F, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0},  // R11 0 still in service
    {4'd11, 8'h6F, 1'b1, 1'b0, 1'b1, 1'b1, 3'd0},
    {4'd4,  8'h6F, 1'b1, 1'b1, 1'b0, 1'b0, 3'd0},
    {4'd9,  8'h6F, 1'b1, 1'b0, 1'b1, 1'b0, 3'd0},
    {4'd12, 8'h7F, 1'b1, 1'b0, 1'b0, 1'b1, 3'd4},
    {4'd12, 8'h6F, 1'b1, 1'b0, 1'b0, 1'b1, 3'd4},
    {4'd12, 8'h7F, 1'b1, 1'b1, 1'b0, 1'b0, 3'd0},  // R12 edge with ack
    {4'd12, 8'h7F, 1'b1, 1'b0, 1'b1, 1'b1, 3'd4},
    {4'd4,  8'h7F, 1'b1, 1'b1, 1'b0, 1'b0, 3'd0},
    {4'd9,  8'h7F, 1'b1, 1'b0, 1'b1, 1'b0, 3'd0}
  };

  task automatic check(input int tag, input logic irq_e, input logic [2:0] vec_e);
    checks++;
    if (cpu_irq !== irq_e || cpu_vec !== vec_e) begin
      fails++;
      $display("FAIL R%0d: irq=%0b vec=%0d expected irq=%0b vec=%0d",
               tag, cpu_irq, cpu_vec, irq_e, vec_e);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(1, 1'b0, 3'd0);  // R1 held in reset
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < ROWS; i++) begin
      irq_lines = STIM[i][14:7];
      nest_en   = STIM[i][6];
      cpu_ack   = STIM[i][5];
      cpu_eoi   = STIM[i][4];
      @(negedge clk);
      check(int'(STIM[i][18:15]), STIM[i][3], STIM[i][2:0]);
    end
    cpu_ack = 1'b0;
    cpu_eoi = 1'b0;
    irq_lines = 8'h00;
    @(negedge clk);
    irq_lines = 8'h08;
    @(negedge clk);
    check(2, 1'b1, 3'd3);
    rst_n = 1'b0;  // R1 reset with a request up
    #1;
    check(1, 1'b0, 3'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(2, 1'b1, 3'd3);  // R2 high line after reset is a new edge
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule